// File: doc/BRIEF.md
# UDP Key Request Extractor

This block sits on the receive stream of a network port. It takes Ethernet frames as 32-byte beats, keeps the first three beats of every frame in a small frame store, and decides whether the frame is a key lookup request. A request is an IPv4/UDP frame of exactly 74 bytes, a 42-byte header followed by a 32-byte transaction identifier, sent to the UDP destination port set on `cfgPort`. For a request the block presents the 32-byte identifier as a 256-bit key with a valid/ready handshake. The whole frame stays readable on a frame-store read port, so a later stage can build the reply from it.

Any other frame leaves on a bypass stream with the same data, byte enables and end marker on every beat. The block first replays the beats it has already stored. It then passes the rest of a long frame straight through. While a key waits to be taken, the input is stalled, so the stored frame cannot be overwritten.

Top module: `ukx_request_extractor`

## Requirements
- R1: After reset, `keyValid` and `byValid` are low and `inReady` is high.
- R2: Frame byte j of a beat travels on `inData[8j+7:8j]`. A frame is a request when all of these hold: bytes 12–13 (big-endian) equal 0x0800, byte 23 equals 17, bytes 36–37 (big-endian) equal `cfgPort`, and the frame is exactly 74 bytes. For a request, key byte k equals frame byte 42+k and is presented on `keyData[8k+7:8k]`.
- R3: While `keyValid` is high and `keyReady` is low, `keyValid` stays high, `keyData` is stable and `inReady` is low.
- R4: `keyValid` rises on the clock edge that follows the edge accepting the request's last beat.
- R5: While a key is pending, `fbData` returns beat `fbAddr` (0, 1 or 2) of the request frame, and returns zero for address 3.
- R6: A frame whose bytes 12–13 are not 0x0800 leaves on the bypass output unchanged, beat for beat, and produces no key.
- R7: A frame whose byte 23 is not 17 leaves on the bypass output unchanged and produces no key.
- R8: A frame whose destination port differs from `cfgPort` leaves on the bypass output unchanged and produces no key.
- R9: A frame of any length other than 74 bytes leaves on the bypass output unchanged and produces no key. This covers frames of fewer than three beats, frames of more than three beats, and three-beat frames whose last-beat byte enable is not exactly the low 10 bits. A valid length requires full enables on beats 0 and 1, `inLast` on beat 2 only, and `inKeep` equal to 0x3FF on beat 2.
- R10: While `byValid` is high and `byReady` is low, `byValid`, `byData`, `byKeep` and `byLast` hold their values.
- R11: Data bytes 10–31 of a request's last beat, where byte enables are low, have no effect on the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgPort | input | 16 | UDP destination port that marks a request |
| inValid | input | 1 | Input beat valid |
| inReady | output | 1 | Input beat accepted when high with inValid |
| inData | input | 256 | Input beat, byte j on bits 8j+7:8j |
| inKeep | input | 32 | Input byte enables |
| inLast | input | 1 | Last beat of the frame |
| keyValid | output | 1 | Key available |
| keyReady | input | 1 | Key taken when high with keyValid |
| keyData | output | 256 | Transaction identifier, byte k on bits 8k+7:8k |
| byValid | output | 1 | Bypass beat valid |
| byReady | input | 1 | Bypass beat taken when high with byValid |
| byData | output | 256 | Bypass beat data |
| byKeep | output | 32 | Bypass byte enables |
| byLast | output | 1 | Bypass last beat |
| fbAddr | input | 2 | Frame-store beat select |
| fbData | output | 256 | Frame-store beat read (combinational) |

## Verification
The key becomes valid exactly one edge after the edge that accepts the request's last beat, because one cycle goes to classifying the stored frame. The bench notes the cycle count at that handshake and checks the rise of `keyValid` two counts later. Bypass beats start on the second edge after the frame ends or its third beat arrives. Their timing depends on backpressure, so the bench compares them in order against a queue of expected beats, whenever a handshake is seen. Frame-store reads are combinational and are checked in the same cycle that `fbAddr` is driven, for every cycle in which a key is pending.

// File: rtl/ukx_pkg.sv
package ukx_pkg;
  // index width wide enough to count up to three stored beats
  localparam int IDX_W = 2;
  typedef logic [IDX_W-1:0] beatIdx_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     capture;   // store the input beat at capIdx
    beatIdx_t capIdx;
    beatIdx_t rdIdx;     // stored beat to replay on bypass
    logic     passThru;  // bypass carries the live input beat
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_RECV, ST_CHECK, ST_KEY, ST_REPLAY, ST_PASS
  } ctlState_t;
endpackage

// File: rtl/ukx_datapath.sv
module ukx_datapath
  import ukx_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_BEATS  = 3,
  parameter int LAST_BYTES = 10,
  parameter int KEY_OFS    = 42,
  parameter int KEY_BYTES  = 32,
  parameter int ETYPE_OFS  = 12,
  parameter int PROTO_OFS  = 23,
  parameter int PORT_OFS   = 36,
  parameter logic [15:0] ETYPE_VAL = 16'h0800,
  parameter logic [7:0]  PROTO_VAL = 8'h11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [15:0]             cfgPort,
  input  logic [DATA_BYTES*8-1:0] inData,
  input  logic [DATA_BYTES-1:0]   inKeep,
  input  logic                    inLast,
  input  beatIdx_t                fbAddr,
  output logic                    matchOk,
  output logic [KEY_BYTES*8-1:0]  keyData,
  output logic [DATA_BYTES*8-1:0] byData,
  output logic [DATA_BYTES-1:0]   byKeep,
  output logic                    byLast,
  output logic [DATA_BYTES*8-1:0] fbData
);
  localparam int DATA_W = DATA_BYTES * 8;
  localparam int FLAT_W = DATA_W * NUM_BEATS;
  localparam int KEY_W  = KEY_BYTES * 8;
  localparam logic [DATA_BYTES-1:0] LAST_KEEP =
    {{(DATA_BYTES-LAST_BYTES){1'b0}}, {LAST_BYTES{1'b1}}};

  logic [DATA_W-1:0]     bufData [NUM_BEATS];
  logic [DATA_BYTES-1:0] bufKeep [NUM_BEATS];
  logic [NUM_BEATS-1:0]  bufLast;
  logic [FLAT_W-1:0]     bufFlat;
  logic [NUM_BEATS-1:0]  beatOk;

  for (genvar i = 0; i < NUM_BEATS; i++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufData[i] <= '0;
        bufKeep[i] <= '0;
        bufLast[i] <= 1'b0;
      end else if (ctl.capture && ctl.capIdx == beatIdx_t'(i)) begin
        bufData[i] <= inData;
        bufKeep[i] <= inKeep;
        bufLast[i] <= inLast;
      end
    end

    assign bufFlat[i*DATA_W +: DATA_W] = bufData[i];

    if (i == NUM_BEATS - 1) begin : g_end
      assign beatOk[i] = (bufKeep[i] == LAST_KEEP) && bufLast[i];
    end else begin : g_mid
      assign beatOk[i] = (&bufKeep[i]) && !bufLast[i];
    end
  end

  // header fields, big-endian on the wire
  logic [15:0] etype, dstPort;
  logic [7:0]  proto;
  assign etype   = {bufFlat[ETYPE_OFS*8 +: 8], bufFlat[(ETYPE_OFS+1)*8 +: 8]};
  assign proto   = bufFlat[PROTO_OFS*8 +: 8];
  assign dstPort = {bufFlat[PORT_OFS*8 +: 8], bufFlat[(PORT_OFS+1)*8 +: 8]};

  assign matchOk = (&beatOk) && (etype == ETYPE_VAL) &&
                   (proto == PROTO_VAL) && (dstPort == cfgPort);

  // key straddles the beat boundary; taken from the flattened store
  assign keyData = bufFlat[KEY_OFS*8 +: KEY_W];

  logic unusedFlat;
  assign unusedFlat = ^bufFlat;

  always_comb begin
    if (ctl.passThru) begin
      byData = inData;
      byKeep = inKeep;
      byLast = inLast;
    end else if (int'(ctl.rdIdx) < NUM_BEATS) begin
      byData = bufData[ctl.rdIdx];
      byKeep = bufKeep[ctl.rdIdx];
      byLast = bufLast[ctl.rdIdx];
    end else begin
      byData = '0;
      byKeep = '0;
      byLast = 1'b0;
    end
  end

  always_comb begin
    if (int'(fbAddr) < NUM_BEATS) fbData = bufData[fbAddr];
    else                          fbData = '0;
  end
endmodule

// File: rtl/ukx_control.sv
module ukx_control
  import ukx_pkg::*;
#(
  parameter int NUM_BEATS = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  output logic   inReady,
  input  logic   matchOk,
  output logic   keyValid,
  input  logic   keyReady,
  output logic   byValid,
  input  logic   byReady,
  output dpCtl_t ctl
);
  localparam beatIdx_t LAST_IDX = beatIdx_t'(NUM_BEATS - 1);
  localparam beatIdx_t FULL_CNT = beatIdx_t'(NUM_BEATS);

  ctlState_t state;
  beatIdx_t  cnt, rIdx;
  logic      ended;

  always_comb begin
    ctl      = '0;
    inReady  = 1'b0;
    keyValid = 1'b0;
    byValid  = 1'b0;
    ctl.capIdx = cnt;
    ctl.rdIdx  = rIdx;
    case (state)
      ST_RECV: begin
        inReady     = 1'b1;
        ctl.capture = inValid;
      end
      ST_KEY:    keyValid = 1'b1;
      ST_REPLAY: byValid  = 1'b1;
      ST_PASS: begin
        ctl.passThru = 1'b1;
        byValid      = inValid;
        inReady      = byReady;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RECV;
      cnt   <= '0;
      rIdx  <= '0;
      ended <= 1'b0;
    end else begin
      case (state)
        ST_RECV: if (inValid) begin
          cnt   <= cnt + 1'b1;
          ended <= inLast;
          if (inLast || cnt == LAST_IDX) state <= ST_CHECK;
        end
        ST_CHECK: begin
          rIdx <= '0;
          if (ended && cnt == FULL_CNT && matchOk) state <= ST_KEY;
          else                                     state <= ST_REPLAY;
        end
        ST_KEY: if (keyReady) begin
          cnt   <= '0;
          state <= ST_RECV;
        end
        ST_REPLAY: if (byReady) begin
          if (rIdx == cnt - 1'b1) begin
            cnt   <= '0;
            state <= ended ? ST_RECV : ST_PASS;
          end else begin
            rIdx <= rIdx + 1'b1;
          end
        end
        ST_PASS: if (inValid && byReady && inLast) state <= ST_RECV;
        default: state <= ST_RECV;
      endcase
    end
  end

  // R3: a key once offered stays offered until taken
  p_key_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && !keyReady |=> keyValid);

  // R4: a key appears one edge after the accepting edge of a last beat
  p_key_timing_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(keyValid) |-> $past(inValid && inReady && inLast, 2));
endmodule

// File: rtl/ukx_request_extractor.sv
module ukx_request_extractor
  import ukx_pkg::*;
#(
  parameter int DATA_BYTES = 32,
  parameter int NUM_BEATS  = 3,
  parameter int LAST_BYTES = 10,
  parameter int KEY_OFS    = 42,
  parameter int KEY_BYTES  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [15:0]             cfgPort,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [DATA_BYTES*8-1:0] inData,
  input  logic [DATA_BYTES-1:0]   inKeep,
  input  logic                    inLast,
  output logic                    keyValid,
  input  logic                    keyReady,
  output logic [KEY_BYTES*8-1:0]  keyData,
  output logic                    byValid,
  input  logic                    byReady,
  output logic [DATA_BYTES*8-1:0] byData,
  output logic [DATA_BYTES-1:0]   byKeep,
  output logic                    byLast,
  input  logic [1:0]              fbAddr,
  output logic [DATA_BYTES*8-1:0] fbData
);
  dpCtl_t ctl;
  logic   matchOk;

  ukx_control #(.NUM_BEATS(NUM_BEATS)) i_ctl (
    .clk, .rstN, .inValid, .inLast, .inReady, .matchOk,
    .keyValid, .keyReady, .byValid, .byReady, .ctl
  );

  ukx_datapath #(
    .DATA_BYTES(DATA_BYTES), .NUM_BEATS(NUM_BEATS), .LAST_BYTES(LAST_BYTES),
    .KEY_OFS(KEY_OFS), .KEY_BYTES(KEY_BYTES)
  ) i_dp (
    .clk, .rstN, .ctl, .cfgPort, .inData, .inKeep, .inLast,
    .fbAddr(beatIdx_t'(fbAddr)), .matchOk, .keyData, .byData, .byKeep,
    .byLast, .fbData
  );

  // R3: pending key contents do not move
  p_key_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    keyValid && !keyReady |=> $stable(keyData));

  // R5: nothing is written into the store while a key waits
  p_no_overwrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |-> !ctl.capture);

  // R10: a stalled bypass beat holds still
  p_by_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    byValid && !byReady |=> byValid && $stable(byData) && $stable(byKeep)
                            && $stable(byLast));
endmodule

// File: tb/test_ukx_request_extractor.sv
module test_ukx_request_extractor;
  localparam logic [15:0] PORT = 16'h1F90;

  logic clk = 1'b0, rstN = 1'b0;
  logic [15:0] cfgPort = PORT;
  logic inValid = 0, inLast = 0, keyReady = 0, byReady = 0;
  logic [255:0] inData = '0;
  logic [31:0] inKeep = '0;
  logic [1:0] fbAddr = '0;
  logic inReady, keyValid, byValid, byLast;
  logic [255:0] keyData, byData, fbData;
  logic [31:0] byKeep;

  ukx_request_extractor i_ukx_request_extractor (
    .clk, .rstN, .cfgPort, .inValid, .inReady, .inData, .inKeep, .inLast,
    .keyValid, .keyReady, .keyData, .byValid, .byReady, .byData, .byKeep,
    .byLast, .fbAddr, .fbData
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, lastAcc = 0;
  bit running = 1'b0, finished = 1'b0;
  logic [7:0] frm [128];
  logic [288:0] expBy [$];
  logic [255:0] expKey [$];
  logic [767:0] expFb [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [288:0] act,
                     input logic [288:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // kind: 0 good, 1 bad ethertype, 2 bad protocol, 3 bad port
  task automatic sendFrame(input int kind, input int len);
    int nb;
    logic [255:0] d;
    logic [31:0] k;
    logic [255:0] key;
    logic [767:0] fb;
    for (int i = 0; i < 128; i++) frm[i] = 8'($urandom);
    frm[12] = (kind == 1) ? 8'h86 : 8'h08;
    frm[13] = (kind == 1) ? 8'hDD : 8'h00;
    frm[23] = (kind == 2) ? 8'h06 : 8'h11;
    frm[36] = PORT[15:8];
    frm[37] = (kind == 3) ? PORT[7:0] ^ 8'h01 : PORT[7:0];
    nb = (len + 31) / 32;
    if (kind == 0 && len == 74) begin
      for (int i = 0; i < 32; i++) key[8*i +: 8] = frm[42+i];
      for (int i = 0; i < 96; i++) fb[8*i +: 8] = frm[i];
      expKey.push_back(key);
      expFb.push_back(fb);
    end
    for (int b = 0; b < nb; b++) begin
      for (int j = 0; j < 32; j++) begin
        d[8*j +: 8] = frm[b*32+j];
        k[j] = (b*32 + j) < len;
      end
      if (!(kind == 0 && len == 74)) expBy.push_back({b == nb-1, k, d});
    end
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      if ($urandom % 5 == 0) begin
        inValid = 1'b0;
        @(negedge clk);
      end
      for (int j = 0; j < 32; j++) begin
        d[8*j +: 8] = frm[b*32+j];
        k[j] = (b*32 + j) < len;
      end
      inValid = 1'b1; inData = d; inKeep = k; inLast = (b == nb-1);
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
      if (inLast) lastAcc = cyc;
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // output sink and checker
  initial begin
    bit prevKey = 0, byHeld = 0;
    logic [288:0] heldBy = '0, got;
    logic [767:0] fbw;
    wait (running);
    while (!finished) begin
      @(negedge clk);
      byReady = ($urandom % 4) != 0;
      keyReady = ($urandom % 3) == 0;
      fbAddr = 2'($urandom);
      #1;
      got = {byLast, byKeep, byData};
      if (byHeld) chk(byValid && got == heldBy, "R10", got, heldBy);
      byHeld = byValid && !byReady;
      heldBy = got;
      if (keyValid && !prevKey)
        chk(cyc == lastAcc + 2, "R4", 289'(cyc), 289'(lastAcc + 2));
      prevKey = keyValid && !keyReady;
      if (keyValid) begin
        chk(!inReady, "R3", 289'(inReady), 289'(0));
        if (expFb.size() == 0) chk(0, "R5", 289'(fbData), 289'(0));
        else begin
          fbw = expFb[0];
          if (fbAddr == 2'd3) chk(fbData == '0, "R5", 289'(fbData), 289'(0));
          else chk(fbData == fbw[256*fbAddr +: 256], "R5", 289'(fbData),
                   289'(fbw[256*fbAddr +: 256]));
        end
      end
      if (keyValid && keyReady) begin
        if (expKey.size() == 0) chk(0, "R6 unexpected key", 289'(keyData), 289'(0));
        else begin
          // R2, R11: key bytes 42..73, tail garbage must not leak in
          chk(keyData == expKey[0], "R2,R11", 289'(keyData), 289'(expKey[0]));
          void'(expKey.pop_front());
          void'(expFb.pop_front());
        end
      end
      if (byValid && byReady) begin
        if (expBy.size() == 0) chk(0, "R9 unexpected bypass", got, '0);
        else begin
          chk(got == expBy[0], "R6,R7,R8,R9", got, expBy[0]);
          void'(expBy.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [11] = '{20, 32, 40, 64, 65, 73, 75, 90, 96, 97, 120};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(inReady && !keyValid && !byValid, "R1",
        289'({inReady, keyValid, byValid}), 289'(3'b100));
    running = 1'b1;
    sendFrame(0, 74);    // R2
    sendFrame(1, 74);    // R6
    sendFrame(2, 74);    // R7
    sendFrame(3, 74);    // R8
    sendFrame(0, 64);    // R9 two beats
    sendFrame(0, 73);    // R9 short keep
    sendFrame(0, 75);    // R9 long keep
    sendFrame(0, 20);    // R9 one beat
    sendFrame(0, 120);   // R9 four beats
    sendFrame(0, 74);
    sendFrame(0, 74);
    for (int n = 0; n < 80; n++) begin
      int kind, len;
      kind = ($urandom % 2 == 0) ? 0 : int'($urandom % 4);
      len = ($urandom % 5 < 3) ? 74 : lens[$urandom % 11];
      sendFrame(kind, len);
    end
    for (int w = 0; w < 2000 && (expBy.size() != 0 || expKey.size() != 0); w++)
      @(negedge clk);
    chk(expBy.size() == 0, "R9 missing bypass", 289'(expBy.size()), 289'(0));
    chk(expKey.size() == 0, "R2 missing key", 289'(expKey.size()), 289'(0));
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule